// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block runs whole register or EEPROM transactions on an I2C bus by issuing a stream of byte-level commands to a separate bit engine, which owns all SCL/SDA timing. A request names one of three operations: probe, read or write. It also carries a 7-bit device address, an internal address of zero to `ADDR_BYTES` bytes and a byte count. The sequencer then walks the bus through START, address bytes, data bytes, repeated start and STOP. Write data comes in on a valid/ready byte stream. Read data leaves on a valid/ready byte stream, and the final byte carries a last flag.

For parts that hide high internal-address bits in the device-address field, a fold mask is applied. The address bits above the configured address length are shifted down, masked and ORed into the device address. A mask of zero disables folding. At the end of every transaction the block pulses `done` and reports a status code, together with the number of write data bytes the device rejected.

FSM states: IDLE (accepts a request), START (first start condition), DEVW (device address with write bit), ADDR (internal address bytes, most significant first), MIDSTOP (stop between the address and read phases), RESTART (second start), DEVR (device address with read bit), RDBYTE (receive one byte), RDPUSH (offer it on the read stream), WRFETCH (take one byte from the write stream), WRBYTE (send it), STOP (closing stop), DONE (report, one cycle).

Transitions:
- IDLE→START on an accepted request.
- START→DEVR when a read has no address bytes; otherwise START→DEVW.
- DEVW→STOP on a NACK or for a probe. DEVW→ADDR when there are address bytes. DEVW→WRFETCH or STOP for a write without address bytes.
- ADDR→STOP on a NACK. ADDR→ADDR while bytes remain. ADDR→MIDSTOP for a read, or WRFETCH/STOP for a write.
- MIDSTOP→RESTART→DEVR.
- DEVR→RDBYTE, or STOP when the count is zero.
- RDBYTE→RDPUSH, then RDPUSH→RDBYTE or STOP.
- WRFETCH→WRBYTE, then WRBYTE→WRFETCH or STOP.
- STOP→DONE→IDLE.

Top module: `i2c_txn_seq`

## Requirements
- R1: A probe (op code 0) issues START, a WRITE of {dev,0}, then STOP. It reports status 0 (ok) if the device acknowledges that byte, and status 1 (no device) if it does not.
- R2: A read (op code 1) with nonzero address length issues START, a WRITE of {dev,0}, the address bytes most significant first, STOP, START, and a WRITE of {dev,1}.
- R3: A read with address length zero issues START followed directly by a WRITE of {dev,1}, with no address phase.
- R4: Each READ command (engine code 3) has `eng_rd_nack` = 0, except the last of the transaction, which has 1. A STOP follows the last READ. Received bytes appear on `rd_data` in order, and `rd_last` = 1 only on the final byte.
- R5: If {dev,0} is not acknowledged, the sequencer issues STOP and reports status 1. No write data byte is taken from the stream.
- R6: If any internal address byte is not acknowledged, the sequencer issues STOP and reports status 2 (address error).
- R7: During a write (op code 2), a data byte that is not acknowledged does not stop the transfer. Each such byte increments `fail_cnt`, STOP follows the last byte, and status is 0.
- R8: The device address sent is dev | ((addr >> 8*alen) & ovf_mask). With alen equal to `ADDR_BYTES`, nothing is folded.
- R9: The acknowledge of {dev,1} is ignored: data reception proceeds and the status is 0 even when that byte is NACKed.
- R10: An offered engine command holds its code, byte and NACK flag until accepted. An offered read byte holds its data and last flag until `rd_ready`.
- R11: `req_ready` is high only in idle, with no command, read byte or write fetch pending. `done` is a single-cycle pulse. Engine command codes are START=0, STOP=1, WRITE=2, READ=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_op | input | 2 | 0 probe, 1 read, 2 write |
| req_dev | input | 7 | 7-bit device address |
| req_addr | input | 8*ADDR_BYTES | Internal address |
| req_alen | input | ALEN_W | Number of address bytes, 0..ADDR_BYTES |
| req_len | input | LEN_W | Number of data bytes |
| ovf_mask | input | 7 | Mask for folding high address bits into the device address |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| rd_last | output | 1 | Final byte of the read |
| eng_cmd_valid | output | 1 | Command to the bit engine offered |
| eng_cmd_ready | input | 1 | Engine accepts the command |
| eng_cmd | output | 2 | START=0, STOP=1, WRITE=2, READ=3 |
| eng_wdata | output | 8 | Byte for a WRITE command |
| eng_rd_nack | output | 1 | For READ: 1 to NACK the received byte |
| eng_rsp_valid | input | 1 | Engine finished the accepted command |
| eng_rsp_nack | input | 1 | For WRITE: the byte was not acknowledged |
| eng_rsp_data | input | 8 | For READ: the received byte |
| done | output | 1 | Transaction complete (one cycle) |
| status | output | 2 | 0 ok, 1 no device, 2 address error |
| fail_cnt | output | LEN_W | Rejected write data bytes |

## Verification
On every cycle the assertions check the engine command and read stream hold rules, that `done` lasts one cycle, that an idle sequencer offers nothing, and that a reported status is one of the three legal codes. Only the bench's scenarios can show the command order of each operation, where a transaction is cut short on a NACK, the rejected-byte count, the fold arithmetic, and that a NACKed read-phase device address is ignored. To show them, the bench compares every accepted engine command and every delivered read byte against a queue of expected items.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        ECMD_START = 2'd0,
        ECMD_STOP  = 2'd1,
        ECMD_WRITE = 2'd2,
        ECMD_READ  = 2'd3
    } ecmd_e;

    typedef enum logic [1:0] {
        OP_PROBE = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_NODEV   = 2'd1,
        RES_ADDRERR = 2'd2
    } res_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_DEVW,
        S_ADDR,
        S_MIDSTOP,
        S_RESTART,
        S_DEVR,
        S_RDBYTE,
        S_RDPUSH,
        S_WRFETCH,
        S_WRBYTE,
        S_STOP,
        S_DONE
    } seq_state_e;

endpackage

// File: rtl/i2c_seq_fold.sv
module i2c_seq_fold #(
    parameter int ADDR_BYTES = 4,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int ALEN_W    = $clog2(ADDR_BYTES + 1)
) (
    input  logic [6:0]        dev,
    input  logic [6:0]        mask,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ALEN_W-1:0] alen,
    input  logic [ALEN_W-1:0] idx,
    output logic [6:0]        dev_eff,
    output logic [7:0]        addr_byte
);
    // bits above the address length, moved down to bit 0
    logic [6:0] spill;

    assign spill     = 7'(addr >> {alen, 3'b000});
    assign dev_eff   = dev | (spill & mask);
    assign addr_byte = 8'(addr >> {idx, 3'b000});
endmodule

// File: rtl/i2c_seq_cmdport.sv
module i2c_seq_cmdport (
    input  logic clk,
    input  logic rst_n,
    input  logic want,
    input  logic cmd_ready,
    input  logic rsp_valid,
    output logic cmd_valid,
    output logic fire
);
    logic issued;

    assign cmd_valid = want && !issued;
    assign fire      = issued && rsp_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issued <= 1'b0;
        end else if (cmd_valid && cmd_ready) begin
            issued <= 1'b1;
        end else if (fire) begin
            issued <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2c_seq_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int LEN_W      = 16,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int ALEN_W    = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [6:0]        req_dev,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ALEN_W-1:0] req_alen,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [6:0]        ovf_mask,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [7:0]        rd_data,
    output logic              rd_last,
    output logic              eng_cmd_valid,
    input  logic              eng_cmd_ready,
    output logic [1:0]        eng_cmd,
    output logic [7:0]        eng_wdata,
    output logic              eng_rd_nack,
    input  logic              eng_rsp_valid,
    input  logic              eng_rsp_nack,
    input  logic [7:0]        eng_rsp_data,
    output logic              done,
    output logic [1:0]        status,
    output logic [LEN_W-1:0]  fail_cnt
);
    seq_state_e        state, state_d;
    op_e               op_q;
    logic [6:0]        dev_q, mask_q, dev_eff;
    logic [ADDR_W-1:0] addr_q;
    logic [ALEN_W-1:0] alen_q, idx_q;
    logic [LEN_W-1:0]  len_q, fail_q;
    logic [7:0]        wbuf_q, rbuf_q, addr_byte;
    res_e              res_q;
    logic              want, fire, len_one, len_zero;
    ecmd_e             cmd_sel;

    assign len_one  = (len_q == LEN_W'(1));
    assign len_zero = (len_q == '0);

    i2c_seq_fold #(.ADDR_BYTES(ADDR_BYTES)) u_fold (
        .dev       (dev_q),
        .mask      (mask_q),
        .addr      (addr_q),
        .alen      (alen_q),
        .idx       (idx_q),
        .dev_eff   (dev_eff),
        .addr_byte (addr_byte)
    );

    i2c_seq_cmdport u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .want      (want),
        .cmd_ready (eng_cmd_ready),
        .rsp_valid (eng_rsp_valid),
        .cmd_valid (eng_cmd_valid),
        .fire      (fire)
    );

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_d = S_START;
            S_START:   if (fire) state_d = (op_q == OP_READ && alen_q == '0) ? S_DEVR : S_DEVW;
            S_DEVW: if (fire) begin
                if (eng_rsp_nack || op_q == OP_PROBE) state_d = S_STOP;
                else if (alen_q != '0)               state_d = S_ADDR;
                else                                 state_d = len_zero ? S_STOP : S_WRFETCH;
            end
            S_ADDR: if (fire) begin
                if (eng_rsp_nack)         state_d = S_STOP;
                else if (idx_q != '0)     state_d = S_ADDR;
                else if (op_q == OP_READ) state_d = S_MIDSTOP;
                else                      state_d = len_zero ? S_STOP : S_WRFETCH;
            end
            S_MIDSTOP: if (fire) state_d = S_RESTART;
            S_RESTART: if (fire) state_d = S_DEVR;
            S_DEVR:    if (fire) state_d = len_zero ? S_STOP : S_RDBYTE;
            S_RDBYTE:  if (fire) state_d = S_RDPUSH;
            S_RDPUSH:  if (rd_ready) state_d = len_one ? S_STOP : S_RDBYTE;
            S_WRFETCH: if (wr_valid) state_d = S_WRBYTE;
            S_WRBYTE:  if (fire) state_d = len_one ? S_STOP : S_WRFETCH;
            S_STOP:    if (fire) state_d = S_DONE;
            S_DONE:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            op_q   <= OP_PROBE;
            dev_q  <= '0;
            mask_q <= '0;
            addr_q <= '0;
            alen_q <= '0;
            idx_q  <= '0;
            len_q  <= '0;
            fail_q <= '0;
            wbuf_q <= '0;
            rbuf_q <= '0;
            res_q  <= RES_OK;
        end else begin
            state <= state_d;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    op_q   <= op_e'(req_op);
                    dev_q  <= req_dev;
                    mask_q <= ovf_mask;
                    addr_q <= req_addr;
                    alen_q <= req_alen;
                    len_q  <= req_len;
                    fail_q <= '0;
                    res_q  <= RES_OK;
                end
                S_DEVW: if (fire) begin
                    if (eng_rsp_nack) res_q <= RES_NODEV;
                    idx_q <= alen_q - ALEN_W'(1);
                end
                S_ADDR: if (fire) begin
                    if (eng_rsp_nack) res_q <= RES_ADDRERR;
                    idx_q <= idx_q - ALEN_W'(1);
                end
                S_RDBYTE: if (fire) rbuf_q <= eng_rsp_data;
                S_RDPUSH: if (rd_ready) len_q <= len_q - LEN_W'(1);
                S_WRFETCH: if (wr_valid) wbuf_q <= wr_data;
                S_WRBYTE: if (fire) begin
                    if (eng_rsp_nack) fail_q <= fail_q + LEN_W'(1);
                    len_q <= len_q - LEN_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        want      = 1'b0;
        cmd_sel   = ECMD_START;
        eng_wdata = 8'h00;
        unique case (state)
            S_START, S_RESTART: begin
                want = 1'b1;
            end
            S_MIDSTOP, S_STOP: begin
                want    = 1'b1;
                cmd_sel = ECMD_STOP;
            end
            S_DEVW: begin
                want      = 1'b1;
                cmd_sel   = ECMD_WRITE;
                eng_wdata = {dev_eff, 1'b0};
            end
            S_DEVR: begin
                want      = 1'b1;
                cmd_sel   = ECMD_WRITE;
                eng_wdata = {dev_eff, 1'b1};
            end
            S_ADDR: begin
                want      = 1'b1;
                cmd_sel   = ECMD_WRITE;
                eng_wdata = addr_byte;
            end
            S_WRBYTE: begin
                want      = 1'b1;
                cmd_sel   = ECMD_WRITE;
                eng_wdata = wbuf_q;
            end
            S_RDBYTE: begin
                want    = 1'b1;
                cmd_sel = ECMD_READ;
            end
            default: ;
        endcase
    end

    assign eng_cmd     = cmd_sel;
    assign eng_rd_nack = (state == S_RDBYTE) && len_one;
    assign req_ready   = (state == S_IDLE);
    assign wr_ready    = (state == S_WRFETCH);
    assign rd_valid    = (state == S_RDPUSH);
    assign rd_data     = rbuf_q;
    assign rd_last     = (state == S_RDPUSH) && len_one;
    assign done        = (state == S_DONE);
    assign status      = res_q;
    assign fail_cnt    = fail_q;
endmodule

// File: rtl/i2c_seq_chk.sv
module i2c_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       rd_last,
    input logic       eng_cmd_valid,
    input logic       eng_cmd_ready,
    input logic [1:0] eng_cmd,
    input logic [7:0] eng_wdata,
    input logic       eng_rd_nack,
    input logic       done,
    input logic [1:0] status
);
    // R10: engine command held until accepted
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        eng_cmd_valid && !eng_cmd_ready |=>
            eng_cmd_valid && $stable(eng_cmd) && $stable(eng_wdata) && $stable(eng_rd_nack));

    // R10: read byte held until taken
    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_last));

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: idle offers nothing
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !eng_cmd_valid && !rd_valid && !wr_ready);

    // R6: only legal status codes are reported
    a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status != 2'd3);
endmodule

bind i2c_txn_seq i2c_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .wr_ready      (wr_ready),
    .rd_valid      (rd_valid),
    .rd_ready      (rd_ready),
    .rd_data       (rd_data),
    .rd_last       (rd_last),
    .eng_cmd_valid (eng_cmd_valid),
    .eng_cmd_ready (eng_cmd_ready),
    .eng_cmd       (eng_cmd),
    .eng_wdata     (eng_wdata),
    .eng_rd_nack   (eng_rd_nack),
    .done          (done),
    .status        (status)
);

// File: tb/tb_i2c_txn_seq.sv
module tb_i2c_txn_seq;
    localparam int ADDR_BYTES = 4;
    localparam int LEN_W      = 16;
    localparam int ADDR_W     = 8 * ADDR_BYTES;
    localparam int ALEN_W     = $clog2(ADDR_BYTES + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = '0;
    logic [6:0]        req_dev = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ALEN_W-1:0] req_alen = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [6:0]        ovf_mask = '0;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [7:0]        wr_data = '0;
    logic              rd_valid;
    logic              rd_ready = 1'b0;
    logic [7:0]        rd_data;
    logic              rd_last;
    logic              eng_cmd_valid;
    logic              eng_cmd_ready = 1'b0;
    logic [1:0]        eng_cmd;
    logic [7:0]        eng_wdata;
    logic              eng_rd_nack;
    logic              eng_rsp_valid = 1'b0;
    logic              eng_rsp_nack = 1'b0;
    logic [7:0]        eng_rsp_data = '0;
    logic              done;
    logic [1:0]        status;
    logic [LEN_W-1:0]  fail_cnt;

    i2c_txn_seq #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W)) dut (.*);

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // expected engine commands: {code, byte, nack flag, tag}
    typedef struct { logic [1:0] c; logic [7:0] d; logic n; string tag; } ecmd_t;
    typedef struct { logic [7:0] d; logic last; string tag; } rbyte_t;
    ecmd_t      exp_cmd[$];
    rbyte_t     exp_rd[$];
    logic [7:0] wr_q[$];
    logic       nack_plan [16];
    int         wcnt = 0;
    int         rcnt = 0;
    logic [7:0] rd_base = 8'h00;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic ex(input logic [1:0] c, input logic [7:0] d, input logic n, input string tag);
        ecmd_t e;
        e.c = c; e.d = d; e.n = n; e.tag = tag;
        exp_cmd.push_back(e);
    endtask

    task automatic exr(input logic [7:0] d, input logic last, input string tag);
        rbyte_t r;
        r.d = d; r.last = last; r.tag = tag;
        exp_rd.push_back(r);
    endtask

    // engine model, stream sinks/sources and monitor
    initial begin
        bit         acc_pend = 0;
        bit         wr_pop   = 0;
        logic [1:0] acc_c    = '0;
        int         cyc      = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (acc_pend) begin
                eng_rsp_valid = 1'b1;
                eng_rsp_nack  = 1'b0;
                if (acc_c == 2'd2) begin
                    eng_rsp_nack = nack_plan[wcnt % 16];
                    wcnt++;
                end
                if (acc_c == 2'd3) begin
                    eng_rsp_data = rd_base + 8'(rcnt);
                    rcnt++;
                end
                acc_pend = 0;
            end else begin
                eng_rsp_valid = 1'b0;
            end
            eng_cmd_ready = (cyc % 3) != 1;
            if (rst_n && eng_cmd_valid && eng_cmd_ready) begin
                if (exp_cmd.size() == 0) begin
                    check(0, "unexpected command", {22'd0, eng_cmd, eng_wdata}, 32'hFFFF);
                end else begin
                    ecmd_t e;
                    e = exp_cmd.pop_front();
                    check(eng_cmd == e.c && (e.c != 2'd2 || eng_wdata == e.d) &&
                          (e.c != 2'd3 || eng_rd_nack == e.n), e.tag,
                          {eng_cmd, eng_rd_nack, eng_wdata}, {e.c, e.n, e.d});
                end
                acc_pend = 1;
                acc_c    = eng_cmd;
            end
            if (wr_pop) begin
                void'(wr_q.pop_front());
                wr_pop = 0;
            end
            wr_valid = wr_q.size() > 0;
            if (wr_valid) wr_data = wr_q[0];
            if (rst_n && wr_valid && wr_ready) wr_pop = 1;
            rd_ready = (cyc % 4) != 0;
            if (rst_n && rd_valid && rd_ready) begin
                if (exp_rd.size() == 0) begin
                    check(0, "unexpected read byte", {24'd0, rd_data}, 32'hFFFF);
                end else begin
                    rbyte_t r;
                    r = exp_rd.pop_front();
                    check(rd_data == r.d && rd_last == r.last, r.tag,
                          {23'd0, rd_last, rd_data}, {23'd0, r.last, r.d});
                end
            end
        end
    end

    task automatic clear_plan();
        for (int i = 0; i < 16; i++) nack_plan[i] = 1'b0;
    endtask

    task automatic run(input logic [1:0] op, input logic [6:0] dev, input logic [31:0] addr,
                       input int alen, input int len, input logic [6:0] mask,
                       input logic [1:0] exp_st, input int exp_fail, input string tag);
        bit seen = 0;
        wcnt = 0;
        rcnt = 0;
        @(negedge clk);
        req_op = op; req_dev = dev; req_addr = addr;
        req_alen = ALEN_W'(alen); req_len = LEN_W'(len); ovf_mask = mask;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check(seen, {tag, " done"}, 32'(seen), 1);
        check(status == exp_st, {tag, " status"}, 32'(status), 32'(exp_st));
        check(fail_cnt == LEN_W'(exp_fail), {tag, " fail_cnt"}, 32'(fail_cnt), 32'(exp_fail));
        check(exp_cmd.size() == 0, {tag, " commands left"}, exp_cmd.size(), 0);
        check(exp_rd.size() == 0, {tag, " read bytes left"}, exp_rd.size(), 0);
        exp_cmd.delete();
        exp_rd.delete();
        clear_plan();
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R11 watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_plan();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(req_ready && !eng_cmd_valid && !done && !rd_valid && !wr_ready,
              "R11 reset state", {27'd0, req_ready, eng_cmd_valid, done, rd_valid, wr_ready}, 32'h10);

        // R1: probe acknowledged
        ex(0, 0, 0, "R1 probe start"); ex(2, 8'h90, 0, "R1 probe addr"); ex(1, 0, 0, "R1 probe stop");
        run(0, 7'h48, 0, 0, 0, 0, 2'd0, 0, "R1 probe ack");

        // R1: probe not acknowledged
        nack_plan[0] = 1;
        ex(0, 0, 0, "R1 probe start"); ex(2, 8'h92, 0, "R1 probe addr"); ex(1, 0, 0, "R1 probe stop");
        run(0, 7'h49, 0, 0, 0, 0, 2'd1, 0, "R1 probe nack");

        // R2, R4: read with two address bytes, three data bytes
        rd_base = 8'hC0;
        ex(0, 0, 0, "R2 start"); ex(2, 8'hA0, 0, "R2 dev write");
        ex(2, 8'h12, 0, "R2 addr msb"); ex(2, 8'h34, 0, "R2 addr lsb");
        ex(1, 0, 0, "R2 mid stop"); ex(0, 0, 0, "R2 restart"); ex(2, 8'hA1, 0, "R2 dev read");
        ex(3, 0, 0, "R4 read ack"); ex(3, 0, 0, "R4 read ack"); ex(3, 0, 1, "R4 read nack last");
        ex(1, 0, 0, "R4 stop");
        exr(8'hC0, 0, "R4 byte0"); exr(8'hC1, 0, "R4 byte1"); exr(8'hC2, 1, "R4 byte2 last");
        run(1, 7'h50, 32'h1234, 2, 3, 0, 2'd0, 0, "R2 read");

        // R3, R9: read without address, device-read NACKed
        rd_base = 8'h10;
        nack_plan[0] = 1;
        ex(0, 0, 0, "R3 start"); ex(2, 8'h43, 0, "R3 dev read direct");
        ex(3, 0, 0, "R9 read ack"); ex(3, 0, 1, "R9 read nack last"); ex(1, 0, 0, "R9 stop");
        exr(8'h10, 0, "R9 byte0"); exr(8'h11, 1, "R9 byte1 last");
        run(1, 7'h21, 32'hFFFF, 0, 2, 0, 2'd0, 0, "R9 read");

        // R7: write with two rejected data bytes
        nack_plan[3] = 1; nack_plan[5] = 1;
        wr_q.push_back(8'h11); wr_q.push_back(8'h22); wr_q.push_back(8'h33); wr_q.push_back(8'h44);
        ex(0, 0, 0, "R7 start"); ex(2, 8'h78, 0, "R7 dev"); ex(2, 8'h7E, 0, "R7 addr");
        ex(2, 8'h11, 0, "R7 d0"); ex(2, 8'h22, 0, "R7 d1"); ex(2, 8'h33, 0, "R7 d2");
        ex(2, 8'h44, 0, "R7 d3"); ex(1, 0, 0, "R7 stop");
        run(2, 7'h3C, 32'h7E, 1, 4, 0, 2'd0, 2, "R7 write");

        // R5: write to absent device leaves data untouched
        nack_plan[0] = 1;
        wr_q.push_back(8'hAA); wr_q.push_back(8'hBB);
        ex(0, 0, 0, "R5 start"); ex(2, 8'h78, 0, "R5 dev"); ex(1, 0, 0, "R5 stop");
        run(2, 7'h3C, 32'h7E, 1, 2, 0, 2'd1, 0, "R5 nodev");
        check(wr_q.size() == 2, "R5 write data not taken", wr_q.size(), 2);
        wr_q.delete();
        repeat (2) @(negedge clk);

        // R6: second address byte rejected
        nack_plan[2] = 1;
        ex(0, 0, 0, "R6 start"); ex(2, 8'hA0, 0, "R6 dev"); ex(2, 8'hBE, 0, "R6 addr msb");
        ex(2, 8'hEF, 0, "R6 addr lsb"); ex(1, 0, 0, "R6 stop");
        run(1, 7'h50, 32'hBEEF, 2, 2, 0, 2'd2, 0, "R6 addrerr");

        // R8: fold of high address bits into device address
        rd_base = 8'h77;
        ex(0, 0, 0, "R8 start"); ex(2, 8'hA6, 0, "R8 folded dev write"); ex(2, 8'hA5, 0, "R8 addr");
        ex(1, 0, 0, "R8 mid stop"); ex(0, 0, 0, "R8 restart"); ex(2, 8'hA7, 0, "R8 folded dev read");
        ex(3, 0, 1, "R8 read single"); ex(1, 0, 0, "R8 stop");
        exr(8'h77, 1, "R8 byte last");
        run(1, 7'h50, 32'h3A5, 1, 1, 7'h07, 2'd0, 0, "R8 fold");

        // R8, R2: full-width address, nothing folded
        wr_q.push_back(8'h5A);
        ex(0, 0, 0, "R8 start"); ex(2, 8'h54, 0, "R8 dev unfolded");
        ex(2, 8'h11, 0, "R2 a3"); ex(2, 8'h22, 0, "R2 a2"); ex(2, 8'h33, 0, "R2 a1"); ex(2, 8'h44, 0, "R2 a0");
        ex(2, 8'h5A, 0, "R7 data"); ex(1, 0, 0, "R7 stop");
        run(2, 7'h2A, 32'h11223344, 4, 1, 7'h7F, 2'd0, 0, "R8 wide");

        repeat (4) @(negedge clk);
        check(req_ready && !done, "R11 idle after runs", {30'd0, req_ready, done}, 32'h2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule